// File: doc/BRIEF.md
# Interrupt Summary Mask Bank

This block gathers nineteen active-high, level-sensitive interrupt sources into one interrupt line for the processor. The sources are the four INTx wires (A, B, C and D) of each of four PCI slots, plus the bus bridge, the IDE controller and the USB controller. Each source passes through a synchronizer. It is then gated by its own enable bit, and the gated sources are ORed into the processor interrupt.

Software reaches the block through three consecutive byte registers on a simple I/O strobe bus. A write loads the enable bits of the addressed byte only. The enables cannot be read back. A read of the same address returns the synchronized raw source levels, whether or not each source is enabled. The sources are spread across the three bytes in a fixed interleaved order. Software decodes that order, so it is part of the contract.

Top module: `irq_summary_bank`

## Requirements
- R1: The registers decode at `BASE_ADDR` (byte 0), `BASE_ADDR+1` (byte 1) and `BASE_ADDR+2` (byte 2), with default base 0x804. A write to any other address changes no enable bit. A read of any other address returns 0x00.
- R2: A write commits on the clock edge where `io_wr` is high. It loads only the enable byte that is addressed, and the other two bytes keep their values.
- R3: A read returns the synchronized raw source levels and ignores the enable bits. The enable bits cannot be observed through a read.
- R4: In byte 0, bits 0..3 are INTA of slots 0..3, bit 4 is the bridge, bit 5 is IDE, bit 6 is USB and bit 7 is INTB of slot 0. Enable bits use the same positions.
- R5: In byte 1, bits 0..2 are INTB of slots 1..3, bits 3..6 are INTC of slots 0..3 and bit 7 is INTD of slot 0. Enable bits use the same positions.
- R6: In byte 2, bits 0..2 are INTD of slots 1..3. Bits 3..7 are reserved: they read as zero and writes to them enable nothing.
- R7: `cpu_irq` is high when at least one source is high and has its enable bit at 1. It is registered after the synchronizer, so it follows an input change on the third rising edge.
- R8: After reset all enable bits are 0, `cpu_irq` is low and `io_rdata` is 0x00, whatever the source levels are.
- R9: Sources pass through a two-flop synchronizer. A read whose strobe edge is the first or second rising edge after an input change returns the old level. The third such edge returns the new level.
- R10: Read data appears in the cycle after the rising edge that samples `io_rd`. In every other cycle `io_rdata` is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 12 | I/O byte address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| slot_inta | input | 4 | INTA of slots 0..3 |
| slot_intb | input | 4 | INTB of slots 0..3 |
| slot_intc | input | 4 | INTC of slots 0..3 |
| slot_intd | input | 4 | INTD of slots 0..3 |
| bridge_irq | input | 1 | Bus bridge interrupt |
| ide_irq | input | 1 | IDE interrupt |
| usb_irq | input | 1 | USB interrupt |
| cpu_irq | output | 1 | Combined interrupt to the processor |

## Verification
The enable bits cannot be read back, so a wrong enable state shows up only on `cpu_irq`. It appears one edge after the write that set it, and only while the matching source is held active. The bench therefore drives every source high, one at a time, under single-bit enable patterns. A swapped position in the interleaved layout appears in the first read of the affected byte. A lost or extra synchronizer stage shifts the read edge and the interrupt edge by one cycle, which the back-to-back reads expose.

// File: rtl/irqsum_pkg.sv
package irqsum_pkg;

  localparam int IRQ_SLOTS  = 4;
  localparam int IRQ_SRC_N  = 4 * IRQ_SLOTS + 3;
  localparam int IRQ_BYTE_W = 8;
  localparam int IRQ_REG_N  = 3;
  localparam int IRQ_FLAT_W = IRQ_REG_N * IRQ_BYTE_W;

  // Bits of the flat register image that hold a real source
  localparam logic [IRQ_FLAT_W-1:0] IRQ_IMPL_MASK = IRQ_FLAT_W'((1 << IRQ_SRC_N) - 1);

  typedef struct packed {
    logic                 usb;
    logic                 ide;
    logic                 bridge;
    logic [IRQ_SLOTS-1:0] intd;
    logic [IRQ_SLOTS-1:0] intc;
    logic [IRQ_SLOTS-1:0] intb;
    logic [IRQ_SLOTS-1:0] inta;
  } irq_src_t;

  // Place each source at its register position (software decodes this order)
  function automatic logic [IRQ_FLAT_W-1:0] pack_layout(irq_src_t s);
    logic [IRQ_FLAT_W-1:0] v;
    v        = '0;
    v[3:0]   = s.inta;
    v[4]     = s.bridge;
    v[5]     = s.ide;
    v[6]     = s.usb;
    v[7]     = s.intb[0];
    v[10:8]  = s.intb[3:1];
    v[14:11] = s.intc;
    v[15]    = s.intd[0];
    v[18:16] = s.intd[3:1];
    return v;
  endfunction

endpackage

// File: rtl/irqsum_sync.sv
module irqsum_sync #(
  parameter int WIDTH  = 19,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [WIDTH-1:0] nxt;
    if (g == 0) begin : g_first
      assign nxt = d;
    end else begin : g_rest
      assign nxt = stage_q[g-1];
    end
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= nxt;
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/irqsum_mask_regs.sv
module irqsum_mask_regs #(
  parameter int                          REG_N  = 3,
  parameter int                          BYTE_W = 8,
  parameter logic [REG_N*BYTE_W-1:0]     IMPL   = '1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [REG_N-1:0]        wr_sel,
  input  logic [BYTE_W-1:0]       wdata,
  output logic [REG_N*BYTE_W-1:0] mask_q
);

  for (genvar g = 0; g < REG_N; g++) begin : g_byte
    localparam logic [BYTE_W-1:0] KEEP = IMPL[g*BYTE_W +: BYTE_W];
    always_ff @(posedge clk) begin
      if (!rst_n)                  mask_q[g*BYTE_W +: BYTE_W] <= '0;
      else if (wr_en && wr_sel[g]) mask_q[g*BYTE_W +: BYTE_W] <= wdata & KEEP;
    end
  end

endmodule

// File: rtl/irqsum_read_mux.sv
module irqsum_read_mux #(
  parameter int REG_N  = 3,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_en,
  input  logic [REG_N-1:0]        rd_sel,
  input  logic [REG_N*BYTE_W-1:0] status,
  output logic [BYTE_W-1:0]       rdata
);

  logic [BYTE_W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < REG_N; i++) begin
      if (rd_sel[i]) picked = picked | status[i*BYTE_W +: BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= picked;
    else            rdata <= '0;
  end

endmodule

// File: rtl/irq_summary_bank.sv
module irq_summary_bank
  import irqsum_pkg::*;
#(
  parameter int                ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 12'h804,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    io_addr,
  input  logic                 io_wr,
  input  logic                 io_rd,
  input  logic [IRQ_BYTE_W-1:0] io_wdata,
  output logic [IRQ_BYTE_W-1:0] io_rdata,
  input  logic [IRQ_SLOTS-1:0] slot_inta,
  input  logic [IRQ_SLOTS-1:0] slot_intb,
  input  logic [IRQ_SLOTS-1:0] slot_intc,
  input  logic [IRQ_SLOTS-1:0] slot_intd,
  input  logic                 bridge_irq,
  input  logic                 ide_irq,
  input  logic                 usb_irq,
  output logic                 cpu_irq
);

  localparam int REG_N  = IRQ_REG_N;
  localparam int BYTE_W = IRQ_BYTE_W;
  localparam int FLAT_W = IRQ_FLAT_W;

  // Named internal events (used by the bound checker)
  logic [REG_N-1:0]  reg_sel;
  logic              wr_hit;
  logic              rd_hit;
  logic [FLAT_W-1:0] mask_q;
  logic [FLAT_W-1:0] status_flat;
  logic              irq_any;
  logic              cpu_irq_q;

  // Address decode: one select per register byte
  for (genvar g = 0; g < REG_N; g++) begin : g_dec
    assign reg_sel[g] = (io_addr == BASE_ADDR + ADDR_W'(g));
  end

  assign wr_hit = io_wr && (|reg_sel);
  assign rd_hit = io_rd && (|reg_sel);

  // Source synchronizer
  irq_src_t raw_src;
  irq_src_t sync_src;

  assign raw_src = '{usb: usb_irq, ide: ide_irq, bridge: bridge_irq,
                     intd: slot_intd, intc: slot_intc, intb: slot_intb,
                     inta: slot_inta};

  irqsum_sync #(
    .WIDTH  (IRQ_SRC_N),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_src),
    .q     (sync_src)
  );

  assign status_flat = pack_layout(sync_src);

  // Write-only enable storage
  irqsum_mask_regs #(
    .REG_N  (REG_N),
    .BYTE_W (BYTE_W),
    .IMPL   (IRQ_IMPL_MASK)
  ) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_hit),
    .wr_sel (reg_sel),
    .wdata  (io_wdata),
    .mask_q (mask_q)
  );

  // Raw status read path
  irqsum_read_mux #(
    .REG_N  (REG_N),
    .BYTE_W (BYTE_W)
  ) u_rd (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_en  (rd_hit),
    .rd_sel (reg_sel),
    .status (status_flat),
    .rdata  (io_rdata)
  );

  // Combined interrupt
  assign irq_any = |(status_flat & mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) cpu_irq_q <= 1'b0;
    else        cpu_irq_q <= irq_any;
  end

  assign cpu_irq = cpu_irq_q;

endmodule

// File: rtl/irqsum_checker.sv
module irqsum_checker #(
  parameter int REG_N  = 3,
  parameter int BYTE_W = 8,
  parameter int RSV_LO = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [REG_N-1:0]        reg_sel,
  input logic                    wr_hit,
  input logic                    rd_hit,
  input logic [REG_N*BYTE_W-1:0] mask_q,
  input logic [BYTE_W-1:0]       io_rdata,
  input logic                    cpu_irq
);

  p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(reg_sel));

  p_mask_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(mask_q));

  p_rsv_read_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && reg_sel[REG_N-1]) |=> (io_rdata[BYTE_W-1:RSV_LO] == '0));

  p_rsv_mask_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q[REG_N*BYTE_W-1:(REG_N-1)*BYTE_W+RSV_LO] == '0);

  p_masked_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> !cpu_irq);

  p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_hit |=> (io_rdata == '0));

endmodule

bind irq_summary_bank irqsum_checker #(
  .REG_N  (irqsum_pkg::IRQ_REG_N),
  .BYTE_W (irqsum_pkg::IRQ_BYTE_W),
  .RSV_LO (3)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .reg_sel  (reg_sel),
  .wr_hit   (wr_hit),
  .rd_hit   (rd_hit),
  .mask_q   (mask_q),
  .io_rdata (io_rdata),
  .cpu_irq  (cpu_irq)
);

// File: tb/tb_irq_summary_bank.sv
module tb_irq_summary_bank;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic [3:0]  s_a = '0, s_b = '0, s_c = '0, s_d = '0;
  logic        s_br = 1'b0, s_ide = 1'b0, s_usb = 1'b0;
  logic        cpu_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  localparam logic [11:0] BASE = 12'h804;

  always #5 clk = ~clk;

  irq_summary_bank dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata),
    .slot_inta(s_a), .slot_intb(s_b), .slot_intc(s_c), .slot_intd(s_d),
    .bridge_irq(s_br), .ide_irq(s_ide), .usb_irq(s_usb), .cpu_irq(cpu_irq)
  );

  // Bench source index: 0..15 = line*4+slot (line A..D), 16 bridge, 17 ide, 18 usb
  function automatic int pos_of(int idx);
    int line, slot;
    if (idx == 16) return 4;
    if (idx == 17) return 5;
    if (idx == 18) return 6;
    line = idx / 4;
    slot = idx % 4;
    case (line)
      0:       return slot;
      1:       return 7 + slot;
      2:       return 11 + slot;
      default: return 15 + slot;
    endcase
  endfunction

  function automatic logic [23:0] expect_flat(logic [18:0] v);
    logic [23:0] r = '0;
    for (int i = 0; i < 19; i++) if (v[i]) r[pos_of(i)] = 1'b1;
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_src(logic [18:0] v);
    s_a = v[3:0]; s_b = v[7:4]; s_c = v[11:8]; s_d = v[15:12];
    s_br = v[16]; s_ide = v[17]; s_usb = v[18];
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_read(logic [11:0] a, output logic [7:0] d);
    io_addr = a; io_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic do_write(logic [11:0] a, logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic write_mask(logic [23:0] m);
    for (int b = 0; b < 3; b++) do_write(BASE + 12'(b), m[b*8 +: 8]);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic read_all(logic [18:0] v, string req);
    logic [23:0] e;
    logic [7:0] d;
    e = expect_flat(v);
    for (int b = 0; b < 3; b++) begin
      do_read(BASE + 12'(b), d);
      check(d == e[b*8 +: 8], req, {24'h0, d}, {24'h0, e[b*8 +: 8]});
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] d;
    logic [7:0] d1, d2, d3;
    logic [23:0] e;

    // R8: reset with every source active
    drive_src('1);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(io_rdata == 8'h00, "R8 rdata in reset", {24'h0, io_rdata}, 32'h0);
    check(cpu_irq == 1'b0, "R8 irq in reset", {31'h0, cpu_irq}, 32'h0);
    rst_n = 1'b1;
    settle();
    check(cpu_irq == 1'b0, "R8 enables zero after reset", {31'h0, cpu_irq}, 32'h0);

    // R4 R5 R6 R3: walking one over every source
    for (int i = 0; i < 19; i++) begin
      drive_src(19'(1) << i);
      settle();
      read_all(19'(1) << i, "R4/R5/R6 walking source");
    end
    // Mixed patterns
    drive_src(19'h7FFFF); settle(); read_all(19'h7FFFF, "R6 all sources, reserved zero");
    drive_src(19'h5A5A5); settle(); read_all(19'h5A5A5, "R4 pattern 5A5A5");
    drive_src(19'h2C3F1); settle(); read_all(19'h2C3F1, "R5 pattern 2C3F1");

    // R3: enabling everything does not alter the read value
    write_mask(24'hFFFFFF);
    read_all(19'h2C3F1, "R3 read ignores enables");

    // R7: each source alone, enabled and then blocked by its own bit
    for (int i = 0; i < 19; i++) begin
      drive_src(19'(1) << i);
      write_mask(24'hFFFFFF);
      settle();
      check(cpu_irq == 1'b1, "R7 enabled source raises irq", {31'h0, cpu_irq}, 32'h1);
      write_mask(~(24'h1 << pos_of(i)));
      check(cpu_irq == 1'b0, "R7 own bit cleared blocks irq", {31'h0, cpu_irq}, 32'h0);
    end

    // R6 R7: single enable bit over all 24 positions, every source active
    drive_src('1);
    settle();
    for (int p = 0; p < 24; p++) begin
      write_mask(24'h1 << p);
      check(cpu_irq == (p < 19), "R6/R7 single enable bit", {31'h0, cpu_irq}, {31'h0, p < 19});
    end

    // R2: byte writes are independent
    write_mask(24'h0);
    drive_src(19'h00001);                       // INTA slot0 -> byte0 bit0
    settle();
    do_write(BASE, 8'h01);
    do_write(BASE + 12'd1, 8'h00);
    do_write(BASE + 12'd2, 8'h00);
    @(posedge clk); @(negedge clk);
    check(cpu_irq == 1'b1, "R2 other bytes leave byte0", {31'h0, cpu_irq}, 32'h1);
    do_write(BASE + 12'd1, 8'hFF);
    do_write(BASE, 8'h00);
    @(posedge clk); @(negedge clk);
    check(cpu_irq == 1'b0, "R2 byte0 cleared", {31'h0, cpu_irq}, 32'h0);
    drive_src(19'h00100);                       // INTC slot0 -> byte1 bit3
    settle();
    check(cpu_irq == 1'b1, "R2 byte1 kept after byte0 write", {31'h0, cpu_irq}, 32'h1);

    // R1: neighbouring addresses do nothing
    write_mask(24'h0);
    drive_src('1);
    settle();
    do_write(BASE - 12'd1, 8'hFF);
    do_write(BASE + 12'd3, 8'hFF);
    do_write(12'h004, 8'hFF);
    settle();
    check(cpu_irq == 1'b0, "R1 write outside window", {31'h0, cpu_irq}, 32'h0);
    do_read(BASE + 12'd3, d);
    check(d == 8'h00, "R1 read above window", {24'h0, d}, 32'h0);
    do_read(BASE - 12'd1, d);
    check(d == 8'h00, "R1 read below window", {24'h0, d}, 32'h0);

    // R10: data only in the cycle after the strobe
    do_read(BASE, d);
    check(d == 8'hFF, "R10 read data", {24'h0, d}, 32'hFF);
    @(posedge clk); @(negedge clk);
    check(io_rdata == 8'h00, "R10 idle after read", {24'h0, io_rdata}, 32'h0);

    // R9: two-flop latency on reads
    drive_src('0);
    settle();
    drive_src(19'h0000F);
    do_read(BASE, d1);
    do_read(BASE, d2);
    do_read(BASE, d3);
    check(d1 == 8'h00, "R9 first edge old", {24'h0, d1}, 32'h0);
    check(d2 == 8'h00, "R9 second edge old", {24'h0, d2}, 32'h0);
    check(d3 == 8'h0F, "R9 third edge new", {24'h0, d3}, 32'h0F);

    // R7: interrupt latency of three edges
    write_mask(24'hFFFFFF);
    drive_src('0);
    settle();
    drive_src(19'h40000);                       // USB
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(cpu_irq == 1'b0, "R7 low after two edges", {31'h0, cpu_irq}, 32'h0);
    @(posedge clk); @(negedge clk);
    check(cpu_irq == 1'b1, "R7 high on third edge", {31'h0, cpu_irq}, 32'h1);

    // R8: reset clears enables again
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    settle();
    e = expect_flat(19'h40000);
    check(cpu_irq == 1'b0, "R8 enables cleared by reset", {31'h0, cpu_irq}, 32'h0);
    do_read(BASE, d);
    check(d == e[7:0], "R8 status after reset", {24'h0, d}, {24'h0, e[7:0]});

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule